// File: doc/BRIEF.md
# Periodic Down-Counting Timer with Register Port

This block is a single-clock countdown timer sitting behind a word-wide register port. Software programs a reload value and a control word. While the control word's run bit is set, every pulse on the tick-enable input lowers a live count by one. When the count has hit zero and the control word's auto-reload bit is also set, the next tick copies the reload value back into the count. That same auto-reload bit enables the interrupt. The interrupt output pulses for one cycle after any tick that leaves the count at zero while that bit is set. A plain scratch register and a read-only view of the live count complete the register set.

The port takes one request per cycle and answers in the following cycle. Only full-word requests to one of the four word-aligned offsets are accepted. Any other request raises a one-cycle error pulse, returns zero data and changes nothing. Register values travel over the data buses in big-endian byte order. The tick-enable input is expected to come from a prescaler elsewhere in the same clock domain.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, the scratch, control, reload and live-count registers all read zero, and irq_o and rsp_err_o are low.
- R2: The scratch register at offset 0x0 is plain read/write storage. No tick or counter activity ever changes it.
- R3: Byte lane k of a data bus is bits [8k+7:8k] and carries the byte at address offset k. Offset 0 holds the most significant byte of the register value, so register value = {lane0, lane1, lane2, lane3}. This applies in both directions.
- R4: The live count is at offset 0xC and is read-only. A write there is an illegal access and leaves the count unchanged.
- R5: The count holds its value in any cycle without a tick, and on any tick while control bit 2 (run) is 0.
- R6: On a tick with run set and a nonzero count, the count decreases by exactly one.
- R7: On a tick with run set and a count already at zero, the count takes the reload register (offset 0x8) if control bit 0 (auto-reload) is 1, and otherwise stays at zero. Reload therefore happens one tick after zero is reached.
- R8: irq_o is high for exactly one cycle, the cycle after a tick whose updated count is zero while control bit 0 is 1. It is low at all other times.
- R9: A write to control (0x4) or reload (0x8) in the same cycle as a tick is applied before that tick's counter update, so that update uses the newly written values.
- R10: A request is illegal if its size is not 4 bytes, its offset is not a multiple of 4, its offset is above 0xC, or it writes 0xC. An illegal request pulses rsp_err_o for one cycle in the next cycle with zero read data, and modifies no register.
- R11: rsp_rdata_o carries the result of a legal read in the cycle after the request. The value is the register as it stood before that edge's updates. In every other cycle rsp_rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle count enable |
| req_valid_i | input | 1 | Register request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte offset of the request |
| req_size_i | input | 3 | Access size in bytes (only 4 is legal) |
| req_wdata_i | input | 32 | Write data, big-endian byte lanes |
| rsp_rdata_o | output | 32 | Read data one cycle after the request, big-endian byte lanes |
| rsp_err_o | output | 1 | One-cycle pulse for an illegal request |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The embedded properties check the counter's step rule on every cycle: hold, decrement by one, reload from the effective reload value, and stay at zero. They also check that the interrupt pulse follows only a tick that leaves the count at zero with auto-reload set, that writes never land outside a decoded strobe, and that error responses carry zero data.

Other behaviours need the directed scenarios. These are big-endian lane ordering (visible only once a loaded count decrements), a control or reload write taking effect on a tick in the same cycle, the read-only live count, and the read path returning pre-update values.

// File: rtl/tmr_pkg.sv
// Package: shared constants and types for the countdown timer.
// Assumes a word-addressed register file of exactly four slots.
package tmr_pkg;
    localparam int NREGS = 4;

    typedef enum logic [1:0] {
        SEL_SCRATCH = 2'd0,
        SEL_CTRL    = 2'd1,
        SEL_RELOAD  = 2'd2,
        SEL_COUNT   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmr_access_decode.sv
// Module: tmr_access_decode
// Classifies a register request as legal or illegal and produces one-hot
// write strobes and a read select. Assumes byte offsets and a byte count.
module tmr_access_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int SIZE_W = 3,
    parameter int NBYTES = 4
) (
    input  logic                 valid_i,
    input  logic                 write_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [SIZE_W-1:0]    size_i,
    output logic                 ok_o,
    output logic                 bad_o,
    output logic                 rd_en_o,
    output reg_sel_e             rd_sel_o,
    output logic [NREGS-1:0]     wr_stb_o
);
    localparam int WORD_LSB = $clog2(NBYTES);
    localparam int WORD_W   = ADDR_W - WORD_LSB;

    logic [WORD_W-1:0] word;
    logic              aligned, mapped, full, ro_hit;

    // Field extraction and legality terms.
    always_comb begin
        word    = addr_i[ADDR_W-1:WORD_LSB];
        aligned = (addr_i[WORD_LSB-1:0] == '0);
        mapped  = (word < WORD_W'(NREGS));
        full    = (size_i == SIZE_W'(NBYTES));
        ro_hit  = write_i && (word == WORD_W'(SEL_COUNT));
        ok_o    = valid_i && aligned && mapped && full && !ro_hit;
        bad_o   = valid_i && !ok_o;
        rd_en_o = ok_o && !write_i;
        rd_sel_o = reg_sel_e'(word[1:0]);
    end

    // One write strobe per register slot.
    for (genvar i = 0; i < NREGS; i++) begin : g_stb
        assign wr_stb_o[i] = ok_o && write_i && (word == WORD_W'(i));
    end
endmodule

// File: rtl/tmr_regs.sv
// Module: tmr_regs
// Holds the scratch, control and reload registers, exposes the values a
// same-cycle tick must see, and muxes the read value. Data is in register
// (not lane) order.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREGS-1:0]  wr_stb_i,
    input  logic [DATA_W-1:0] wr_val_i,
    input  reg_sel_e          rd_sel_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] ctrl_eff_o,
    output logic [DATA_W-1:0] reload_eff_o,
    output logic [DATA_W-1:0] rd_val_o
);
    logic [DATA_W-1:0] scratch_q, ctrl_q, reload_q;

    // Register storage, written only through the decoded strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            ctrl_q    <= '0;
            reload_q  <= '0;
        end else begin
            if (wr_stb_i[SEL_SCRATCH]) scratch_q <= wr_val_i;
            if (wr_stb_i[SEL_CTRL])    ctrl_q    <= wr_val_i;
            if (wr_stb_i[SEL_RELOAD])  reload_q  <= wr_val_i;
        end
    end

    // Write-through view so a same-cycle tick uses freshly written values.
    always_comb begin
        ctrl_eff_o   = wr_stb_i[SEL_CTRL]   ? wr_val_i : ctrl_q;
        reload_eff_o = wr_stb_i[SEL_RELOAD] ? wr_val_i : reload_q;
    end

    // Read multiplexer over the four slots.
    always_comb begin
        unique case (rd_sel_i)
            SEL_SCRATCH: rd_val_o = scratch_q;
            SEL_CTRL:    rd_val_o = ctrl_q;
            SEL_RELOAD:  rd_val_o = reload_q;
            default:     rd_val_o = count_i;
        endcase
    end

    // R10: without a strobe no stored register may move.
    p_no_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i == '0) |=> ($stable(scratch_q) && $stable(ctrl_q) && $stable(reload_q)));

    // R2: the scratch register changes only on its own strobe.
    p_scratch_sw_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i[SEL_SCRATCH] |=> $stable(scratch_q));
endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// The live count and the interrupt pulse. Assumes run/auto-reload and the
// reload value already include any same-cycle register write.
module tmr_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              autoreload_i,
    input  logic [DATA_W-1:0] reload_i,
    output logic [DATA_W-1:0] count_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] count_nxt;
    logic              at_zero;

    // Next-count rule: decrement, reload after zero, or hold.
    always_comb begin
        at_zero   = (count_o == '0);
        count_nxt = count_o;
        if (tick_i && run_i) begin
            if (!at_zero)          count_nxt = count_o - 1'b1;
            else if (autoreload_i) count_nxt = reload_i;
        end
    end

    // Count and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            irq_o   <= 1'b0;
        end else begin
            count_o <= count_nxt;
            irq_o   <= tick_i && autoreload_i && (count_nxt == '0);
        end
    end

    // R5: no tick or not running means the count is frozen.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i || !run_i) |=> $stable(count_o));

    // R6: running tick on a nonzero count decrements by one.
    p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

    // R7: running tick at zero reloads, or stays at zero without auto-reload.
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && count_o == '0 && autoreload_i) |=> (count_o == $past(reload_i)));
    p_zero_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && count_o == '0 && !autoreload_i) |=> (count_o == '0));

    // R8: the pulse follows only a tick that leaves a zero count with the enable set.
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(tick_i) && $past(autoreload_i) && count_o == '0));
    p_irq_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_i) && $past(autoreload_i) && count_o == '0) |-> irq_o);
endmodule

// File: rtl/tick_down_timer.sv
// Module: tick_down_timer (top)
// Register-mapped countdown timer. Converts between big-endian byte lanes
// and register order, ties decode, storage and counter together, and
// registers the one-cycle-late read/error response. Single clock domain.
module tick_down_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int SIZE_W     = 3,
    parameter int RUN_BIT    = 2,
    parameter int RELOAD_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [SIZE_W-1:0] req_size_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              rsp_err_o,
    output logic              irq_o
);
    localparam int NBYTES = DATA_W / 8;

    logic              ok, bad, rd_en;
    reg_sel_e          rd_sel;
    logic [NREGS-1:0]  wr_stb;
    logic [DATA_W-1:0] wr_val, rd_val, rd_lanes;
    logic [DATA_W-1:0] ctrl_eff, reload_eff, count;

    // Byte-lane reordering: lane k <-> register byte (NBYTES-1-k).
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign wr_val[DATA_W-1-8*k -: 8]  = req_wdata_i[8*k +: 8];
        assign rd_lanes[8*k +: 8]         = rd_val[DATA_W-1-8*k -: 8];
    end

    tmr_access_decode #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .NBYTES(NBYTES)
    ) u_decode (
        .valid_i (req_valid_i),
        .write_i (req_write_i),
        .addr_i  (req_addr_i),
        .size_i  (req_size_i),
        .ok_o    (ok),
        .bad_o   (bad),
        .rd_en_o (rd_en),
        .rd_sel_o(rd_sel),
        .wr_stb_o(wr_stb)
    );

    tmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb_i    (wr_stb),
        .wr_val_i    (wr_val),
        .rd_sel_i    (rd_sel),
        .count_i     (count),
        .ctrl_eff_o  (ctrl_eff),
        .reload_eff_o(reload_eff),
        .rd_val_o    (rd_val)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .run_i       (ctrl_eff[RUN_BIT]),
        .autoreload_i(ctrl_eff[RELOAD_BIT]),
        .reload_i    (reload_eff),
        .count_o     (count),
        .irq_o       (irq_o)
    );

    // Response register: read data or zero, plus the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata_o <= '0;
            rsp_err_o   <= 1'b0;
        end else begin
            rsp_rdata_o <= rd_en ? rd_lanes : '0;
            rsp_err_o   <= bad;
        end
    end

    // R10: an error response never carries data.
    p_err_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> (rsp_rdata_o == '0));

    // R10: the error pulse follows an accepted-as-illegal request only.
    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> ($past(req_valid_i) && !$past(ok)));

    // R4: a write aimed at the live count never alters it without a tick.
    p_count_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && req_addr_i == ADDR_W'(12) && !tick_i) |=> $stable(count));

    // R11: with no legal read the data bus is idle at zero.
    p_idle_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rsp_rdata_o == '0));
endmodule

// File: tb/tick_down_timer_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected responses into a queue;
// a monitor pops and compares them one cycle after each request.
module tick_down_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [4:0]  req_addr_i = '0;
    logic [2:0]  req_size_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic [31:0] rsp_rdata_o;
    logic        rsp_err_o;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    logic seen = 1'b0;

    always #2.5 clk = ~clk;

    tick_down_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_size_i(req_size_i),
        .req_wdata_i(req_wdata_i), .rsp_rdata_o(rsp_rdata_o),
        .rsp_err_o(rsp_err_o), .irq_o(irq_o)
    );

    // R3: register value -> lane word (offset 0 = most significant byte).
    function automatic logic [31:0] lanes(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: note a request at the edge, compare at the following negedge.
    always @(posedge clk) seen <= req_valid_i;
    always @(negedge clk) begin
        if (seen && rst_n) begin
            if (sb_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL scoreboard: actual=response expected=none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_rdata_o, e.data, {e.tag, " data"});
                check({31'd0, rsp_err_o}, {31'd0, e.err}, {e.tag, " err"});
            end
        end
    end

    // Driver: one cycle of stimulus; returns at the next negedge.
    task automatic step(input bit v, input bit w, input logic [4:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, input bit tk,
                        input logic [31:0] er, input bit ee, input string tag);
        exp_t e;
        req_valid_i = v; req_write_i = w; req_addr_i = a;
        req_size_i = sz; req_wdata_i = wd; tick_i = tk;
        if (v) begin
            e.data = er; e.err = ee; e.tag = tag;
            sb_q.push_back(e);
        end
        @(negedge clk);
        req_valid_i = 1'b0; req_write_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] val, input bit tk, input string tag);
        step(1, 1, a, 3'd4, lanes(val), tk, 32'd0, 1'b0, tag);
    endtask
    task automatic rd(input logic [4:0] a, input logic [31:0] val, input bit tk, input string tag);
        step(1, 0, a, 3'd4, 32'd0, tk, lanes(val), 1'b0, tag);
    endtask
    task automatic tick1();
        step(0, 0, 5'd0, 3'd0, 32'd0, 1, 32'd0, 1'b0, "");
    endtask
    task automatic idle();
        step(0, 0, 5'd0, 3'd0, 32'd0, 0, 32'd0, 1'b0, "");
    endtask
    task automatic chk_irq(input bit exp, input string tag);
        check({31'd0, irq_o}, {31'd0, exp}, {tag, " irq"});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(0, "R1 reset");
        check({31'd0, rsp_err_o}, 32'd0, "R1 reset err");

        // R1: all registers zero.
        rd(5'h0, 0, 0, "R1 scratch");
        rd(5'h4, 0, 0, "R1 ctrl");
        rd(5'h8, 0, 0, "R1 reload");
        rd(5'hC, 0, 0, "R1 count");

        // R2 / R3: scratch round trip.
        wr(5'h0, 32'hA5A5_1234, 0, "R2 wr");
        rd(5'h0, 32'hA5A5_1234, 0, "R2 rd");

        // R9: control write coinciding with a tick reloads at once.
        wr(5'h8, 3, 0, "R9 reload");
        wr(5'h4, 32'h5, 1, "R9 ctrl+tick");
        chk_irq(0, "R9");
        rd(5'hC, 3, 0, "R9 count");

        // R6 / R3: decrement exposes lane ordering.
        tick1();
        rd(5'hC, 2, 0, "R6/R3 count");
        tick1();
        tick1();
        chk_irq(1, "R8 at zero");
        idle();
        chk_irq(0, "R8 one cycle");
        rd(5'hC, 0, 0, "R7 zero held");
        tick1();
        chk_irq(0, "R7 reload tick");
        rd(5'hC, 3, 0, "R7 reloaded");
        rd(5'h0, 32'hA5A5_1234, 0, "R2 untouched");

        // R7 / R8: run without auto-reload.
        wr(5'h4, 32'h4, 0, "R7 ctrl");
        for (int i = 0; i < 3; i++) tick1();
        chk_irq(0, "R8 disabled");
        tick1();
        rd(5'hC, 0, 0, "R7 no reload");

        // R5: stopped counter holds.
        wr(5'h8, 10, 0, "R5 reload");
        wr(5'h4, 32'h5, 0, "R5 ctrl");
        tick1();
        wr(5'h4, 32'h1, 0, "R5 stop");
        for (int i = 0; i < 3; i++) tick1();
        idle(); idle();
        rd(5'hC, 10, 0, "R5 held");

        // R4: live count is read-only.
        step(1, 1, 5'hC, 3'd4, lanes(7), 0, 32'd0, 1'b1, "R4 write");
        rd(5'hC, 10, 0, "R4 count kept");

        // R10: illegal requests.
        step(1, 1, 5'h4, 3'd2, lanes(32'h4), 0, 32'd0, 1'b1, "R10 size");
        rd(5'h4, 32'h1, 0, "R10 ctrl kept");
        step(1, 0, 5'h6, 3'd4, 32'd0, 0, 32'd0, 1'b1, "R10 misaligned");
        step(1, 0, 5'h10, 3'd4, 32'd0, 0, 32'd0, 1'b1, "R10 unmapped rd");
        step(1, 1, 5'h14, 3'd4, lanes(32'h99), 0, 32'd0, 1'b1, "R10 unmapped wr");
        rd(5'h0, 32'hA5A5_1234, 0, "R10 scratch kept");

        // R11: read racing a tick sees the pre-update value; idle bus is zero.
        wr(5'h4, 32'h5, 0, "R11 ctrl");
        rd(5'hC, 10, 1, "R11 pre-tick");
        rd(5'hC, 9, 0, "R11 post-tick");
        idle();
        check(rsp_rdata_o, 32'd0, "R11 idle data");

        // R9: reload write coinciding with the reload tick.
        for (int i = 0; i < 9; i++) tick1();
        chk_irq(1, "R8 second zero");
        wr(5'h8, 7, 1, "R9 reload+tick");
        rd(5'hC, 7, 0, "R9 new reload");
        wr(5'h4, 32'h0, 1, "R9 stop+tick");
        rd(5'hC, 7, 0, "R9 stop honoured");

        idle(); idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule